// File: doc/BRIEF.md
# Packed Short-Vector Saturating Arithmetic Unit

This block performs one arithmetic operation on two 64-bit words in a single step, treating each word as a packed vector of narrow integer elements. A two-bit width code chooses the element size: 8, 16 or 32 bits. A sign flag chooses between two's-complement and unsigned interpretation. The carry chain never crosses an element boundary. Each element either wraps, saturates to its own range, or picks the smaller or larger of its two inputs.

Two operations do not map each element to an element of the same size. The first adds the absolute differences of all unsigned byte pairs into one scalar. The second narrows the 16-bit elements of both operands into signed bytes and concatenates them. The result and an illegal-width flag are registered, so the result appears one clock after the inputs are presented. A new operation can be issued on every clock.

The block holds no state apart from its output register. The style's state-machine form therefore reduces to that register: it has a reset state (zero result, flag low) and a loaded state that it re-enters on every clock edge.

Top module: `simd_sat_alu`

## Requirements
- R1: Width code `wsel_i` 0 selects 8-bit elements, 1 selects 16-bit elements and 2 selects 32-bit elements. Element k occupies bits [k*W +: W] of each operand and of the result.
- R2: Opcode 0 computes element-wise a+b and opcode 1 computes element-wise a-b, both modulo 2^W. No carry or borrow passes into the neighbouring element.
- R3: Opcode 2 (saturating add) and opcode 3 (saturating subtract) with `sgn_i`=1 clamp each element to the range -2^(W-1) to 2^(W-1)-1.
- R4: Opcodes 2 and 3 with `sgn_i`=0 clamp each element to the range 0 to 2^W-1. An add that overflows gives all ones, and a subtract that goes below zero gives zero.
- R5: Opcode 4 returns the element-wise minimum and opcode 5 returns the element-wise maximum. Elements are compared as signed when `sgn_i`=1 and as unsigned when `sgn_i`=0.
- R6: Opcode 6 sums |a-b| over all eight unsigned bytes and returns the sum zero-extended in the low bits of the result. A legal width code and `sgn_i` have no effect on this operation.
- R7: Opcode 7 converts each 16-bit element to a signed byte, saturating to the range -128 to 127. The four elements of A fill result bytes 0 to 3 and the four elements of B fill bytes 4 to 7, in element order. A legal width code and `sgn_i` have no effect on this operation.
- R8: Width code 3 produces a zero result with `illegal_o`=1 for any opcode. Every legal width code gives `illegal_o`=0.
- R9: The result and `illegal_o` are registered and reflect the inputs present at the previous rising clock edge. An asynchronous active-low reset clears both outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opa_i | input | 64 | Packed operand A |
| opb_i | input | 64 | Packed operand B |
| op_i | input | 3 | Opcode (0 add, 1 sub, 2 sat add, 3 sat sub, 4 min, 5 max, 6 SAD, 7 pack) |
| wsel_i | input | 2 | Element width code (0: 8, 1: 16, 2: 32, 3: illegal) |
| sgn_i | input | 1 | Signed (1) or unsigned (0) element interpretation |
| result_o | output | 64 | Registered packed result |
| illegal_o | output | 1 | Registered illegal-width flag |

## Verification
The bench targets element boundaries. An all-ones lane plus one must leave its neighbour untouched; a design that lets the carry escape would corrupt the next element. Saturation is driven at both ends of both the signed and unsigned ranges: a design that wraps would flip the sign, and one that picks the wrong bound would return the signed limit for unsigned data. Minimum and maximum use operands whose order reverses between signed and unsigned readings. The pack and byte-difference sum are run with every width code and sign flag to show those inputs are ignored. The illegal code is shown to zero the result whatever the opcode.

// File: rtl/simd_pkg.sv
`timescale 1ns/1ps
package simd_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_ADDS = 3'd2,
        OP_SUBS = 3'd3,
        OP_MIN  = 3'd4,
        OP_MAX  = 3'd5,
        OP_SAD  = 3'd6,
        OP_PACK = 3'd7
    } simd_op_e;

    typedef enum logic [1:0] {
        EW_8   = 2'd0,
        EW_16  = 2'd1,
        EW_32  = 2'd2,
        EW_BAD = 2'd3
    } elem_w_e;

endpackage

// File: rtl/simd_lane.sv
`timescale 1ns/1ps
// One element of width W: wrap, saturate, min, max.
module simd_lane
    import simd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  simd_op_e     op,
    input  logic         sgn,
    output logic [W-1:0] r
);
    localparam int EW = W + 2;
    localparam logic signed [EW-1:0] S_HI = {3'b000, {(W-1){1'b1}}};
    localparam logic signed [EW-1:0] S_LO = {3'b111, {(W-1){1'b0}}};
    localparam logic signed [EW-1:0] U_HI = {2'b00, {W{1'b1}}};

    logic signed [EW-1:0] xa, xb, sum, dif, hi, lo;

    function automatic logic [W-1:0] clamp(input logic signed [EW-1:0] x,
                                           input logic signed [EW-1:0] h,
                                           input logic signed [EW-1:0] l);
        if (x > h)      return h[W-1:0];
        else if (x < l) return l[W-1:0];
        else            return x[W-1:0];
    endfunction

    always_comb begin
        xa  = {{2{sgn & a[W-1]}}, a};
        xb  = {{2{sgn & b[W-1]}}, b};
        sum = xa + xb;
        dif = xa - xb;
        hi  = sgn ? S_HI : U_HI;
        lo  = sgn ? S_LO : '0;
        unique case (op)
            OP_ADD:  r = sum[W-1:0];
            OP_SUB:  r = dif[W-1:0];
            OP_ADDS: r = clamp(sum, hi, lo);
            OP_SUBS: r = clamp(dif, hi, lo);
            OP_MIN:  r = (dif < 0) ? a : b;
            OP_MAX:  r = (dif < 0) ? b : a;
            default: r = '0;
        endcase
    end

    always_comb begin
        if (op == OP_ADDS && !sgn)
            assert_usat_add_floor_R4: assert (r >= a);
        if (op == OP_SUBS && !sgn)
            assert_usat_sub_ceil_R4: assert (r <= a);
        if (op == OP_ADDS && sgn && (a[W-1] == b[W-1]))
            assert_ssat_keeps_sign_R3: assert (r[W-1] == a[W-1]);
        if (op == OP_MIN || op == OP_MAX)
            assert_minmax_pick_R5: assert (r == a || r == b);
    end
endmodule

// File: rtl/simd_lane_array.sv
`timescale 1ns/1ps
// Replicates the element unit across the word for one fixed width.
module simd_lane_array
    import simd_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int W      = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  simd_op_e          op,
    input  logic              sgn,
    output logic [DATA_W-1:0] r
);
    localparam int N = DATA_W / W;

    for (genvar i = 0; i < N; i++) begin : g_lane
        simd_lane #(.W(W)) u_lane (
            .a  (a[i*W +: W]),
            .b  (b[i*W +: W]),
            .op (op),
            .sgn(sgn),
            .r  (r[i*W +: W])
        );
    end
endmodule

// File: rtl/simd_sad.sv
`timescale 1ns/1ps
// Sum of absolute differences over unsigned bytes.
module simd_sad #(
    parameter int DATA_W = 64,
    parameter int SAD_W  = $clog2(255 * (DATA_W / 8) + 1)
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [SAD_W-1:0]  sad
);
    localparam int NB = DATA_W / 8;

    logic [7:0] ua, ub, ad;

    always_comb begin
        sad = '0;
        ua  = '0;
        ub  = '0;
        ad  = '0;
        for (int i = 0; i < NB; i++) begin
            ua  = a[i*8 +: 8];
            ub  = b[i*8 +: 8];
            ad  = (ua > ub) ? (ua - ub) : (ub - ua);
            sad = sad + SAD_W'(ad);
        end
    end
endmodule

// File: rtl/simd_pack.sv
`timescale 1ns/1ps
// Narrows signed 16-bit elements of A and B to saturated signed bytes.
module simd_pack #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] r
);
    localparam int NH = DATA_W / 16;

    function automatic logic [7:0] narrow(input logic signed [15:0] x);
        if (x > 16'sd127)       return 8'h7F;
        else if (x < -16'sd128) return 8'h80;
        else                    return x[7:0];
    endfunction

    for (genvar i = 0; i < NH; i++) begin : g_half
        assign r[i*8 +: 8]      = narrow(a[i*16 +: 16]);
        assign r[(i+NH)*8 +: 8] = narrow(b[i*16 +: 16]);
    end
endmodule

// File: rtl/simd_sat_alu.sv
`timescale 1ns/1ps
module simd_sat_alu
    import simd_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [2:0]        op_i,
    input  logic [1:0]        wsel_i,
    input  logic              sgn_i,
    output logic [DATA_W-1:0] result_o,
    output logic              illegal_o
);
    localparam int NWID  = 3;
    localparam int SAD_W = $clog2(255 * (DATA_W / 8) + 1);

    simd_op_e          op_e;
    elem_w_e           wsel_e;
    logic [DATA_W-1:0] lane_res [NWID];
    logic [SAD_W-1:0]  sad_v;
    logic [DATA_W-1:0] pack_v;
    logic [DATA_W-1:0] res_nxt;
    logic              bad_nxt;

    assign op_e   = simd_op_e'(op_i);
    assign wsel_e = elem_w_e'(wsel_i);

    for (genvar k = 0; k < NWID; k++) begin : g_width
        simd_lane_array #(.DATA_W(DATA_W), .W(8 << k)) u_arr (
            .a  (opa_i),
            .b  (opb_i),
            .op (op_e),
            .sgn(sgn_i),
            .r  (lane_res[k])
        );
    end

    simd_sad #(.DATA_W(DATA_W), .SAD_W(SAD_W)) u_sad (
        .a  (opa_i),
        .b  (opb_i),
        .sad(sad_v)
    );

    simd_pack #(.DATA_W(DATA_W)) u_pack (
        .a(opa_i),
        .b(opb_i),
        .r(pack_v)
    );

    // Output selection
    always_comb begin
        bad_nxt = (wsel_e == EW_BAD);
        res_nxt = '0;
        if (!bad_nxt) begin
            unique case (op_e)
                OP_SAD:  res_nxt = DATA_W'(sad_v);
                OP_PACK: res_nxt = pack_v;
                default: begin
                    unique case (wsel_e)
                        EW_8:    res_nxt = lane_res[0];
                        EW_16:   res_nxt = lane_res[1];
                        EW_32:   res_nxt = lane_res[2];
                        default: res_nxt = '0;
                    endcase
                end
            endcase
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o  <= '0;
            illegal_o <= 1'b0;
        end else begin
            result_o  <= res_nxt;
            illegal_o <= bad_nxt;
        end
    end

    assert_illegal_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wsel_i == 2'd3) |=> (illegal_o && result_o == '0));

    assert_legal_flag_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wsel_i != 2'd3) |=> !illegal_o);

    assert_sad_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd6 && wsel_i != 2'd3) |=> (result_o[DATA_W-1:SAD_W] == '0));

    assert_flag_implies_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (result_o == '0));
endmodule

// File: tb/simd_sat_alu_test.sv
`timescale 1ns/1ps
module simd_sat_alu_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] opa = '0, opb = '0;
    logic [2:0]  op = '0;
    logic [1:0]  wsel = '0;
    logic        sgn = 1'b0;
    logic [63:0] result_o;
    logic        illegal_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    simd_sat_alu uut (
        .clk(clk), .rst_n(rst_n), .opa_i(opa), .opb_i(opb), .op_i(op),
        .wsel_i(wsel), .sgn_i(sgn), .result_o(result_o), .illegal_o(illegal_o)
    );

    // Behavioural reference: {illegal, result}
    function automatic logic [64:0] ref_model(logic [63:0] a, logic [63:0] b,
                                              int o, int w, bit s);
        logic [63:0] res = '0;
        longint acc = 0;
        if (w == 3) return {1'b1, 64'd0};
        if (o == 6) begin
            for (int i = 0; i < 8; i++) begin
                longint x = longint'(a[i*8 +: 8]);
                longint y = longint'(b[i*8 +: 8]);
                acc += (x > y) ? x - y : y - x;
            end
            return {1'b0, 64'(acc)};
        end
        if (o == 7) begin
            for (int i = 0; i < 4; i++) begin
                longint x = longint'($signed(a[i*16 +: 16]));
                longint y = longint'($signed(b[i*16 +: 16]));
                x = (x > 127) ? 127 : ((x < -128) ? -128 : x);
                y = (y > 127) ? 127 : ((y < -128) ? -128 : y);
                res[i*8 +: 8]     = 8'(x);
                res[(i+4)*8 +: 8] = 8'(y);
            end
            return {1'b0, res};
        end
        begin
            int W = 8 << w;
            logic [63:0] mask = (64'd1 << W) - 64'd1;
            longint lo = s ? -(longint'(1) << (W-1)) : 0;
            longint hi = s ? (longint'(1) << (W-1)) - 1 : (longint'(1) << W) - 1;
            for (int i = 0; i < 64 / W; i++) begin
                longint va = longint'((a >> (i*W)) & mask);
                longint vb = longint'((b >> (i*W)) & mask);
                longint r = 0;
                if (s && va >= (longint'(1) << (W-1))) va -= longint'(1) << W;
                if (s && vb >= (longint'(1) << (W-1))) vb -= longint'(1) << W;
                case (o)
                    0: r = va + vb;
                    1: r = va - vb;
                    2: r = va + vb;
                    3: r = va - vb;
                    4: r = (va < vb) ? va : vb;
                    default: r = (va > vb) ? va : vb;
                endcase
                if (o == 2 || o == 3) r = (r > hi) ? hi : ((r < lo) ? lo : r);
                res = res | ((64'(r) & mask) << (i*W));
            end
        end
        return {1'b0, res};
    endfunction

    task automatic check(input string tag, input logic [64:0] got, input logic [64:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Called at a falling edge; checks at the next falling edge.
    task automatic apply(input logic [63:0] a, input logic [63:0] b, input int o,
                         input int w, input bit s, input string tag);
        logic [64:0] e;
        opa = a; opb = b; op = 3'(o); wsel = 2'(w); sgn = s;
        e = ref_model(a, b, o, w, s);
        @(negedge clk);
        check(tag, {illegal_o, result_o}, e);
    endtask

    function automatic string tag_of(int o, int w, bit s);
        if (w == 3) return "R8";
        case (o)
            0, 1: return "R2";
            2, 3: return s ? "R3" : "R4";
            4, 5: return "R5";
            6:    return "R6";
            default: return "R7";
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset", {illegal_o, result_o}, 65'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 after release", {illegal_o, result_o}, 65'd0);

        // R1: 32-bit lanes, low lane wraps without touching the high lane
        apply(64'h00000001_FFFFFFFF, 64'h00000000_00000001, 0, 2, 0, "R1");
        apply(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 0, 1, 0, "R1");
        // R2
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 0, 0, 0, "R2");
        apply(64'h0000_0000_0000_0000, 64'h0001_0001_0001_0001, 1, 1, 1, "R2");
        // R3
        apply(64'h7F80_7F80_7F80_7F80, 64'h01FF_01FF_01FF_01FF, 2, 0, 1, "R3");
        apply(64'h80000000_7FFFFFFF, 64'h00000001_FFFFFFFF, 3, 2, 1, "R3");
        // R4
        apply(64'hFFFF_0000_FFFF_1234, 64'h0001_0001_0000_0001, 2, 1, 0, "R4");
        apply(64'h0000_0005_FFFF_0000, 64'h0001_0006_FFFF_0000, 3, 1, 0, "R4");
        // R5: order flips between signed and unsigned reading
        apply(64'h8080_8080_0101_0101, 64'h0101_0101_8080_8080, 4, 0, 1, "R5");
        apply(64'h8080_8080_0101_0101, 64'h0101_0101_8080_8080, 4, 0, 0, "R5");
        apply(64'h80000000_00000005, 64'h00000001_00000003, 5, 2, 1, "R5");
        apply(64'h80000000_00000005, 64'h00000001_00000003, 5, 2, 0, "R5");
        // R6: width code and sign flag ignored
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 6, 0, 0, "R6");
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 6, 2, 1, "R6");
        apply(64'h0010_2030_4050_6070, 64'h7060_5040_3020_1000, 6, 1, 1, "R6");
        // R7
        apply(64'hFF80_0042_8000_7FFF, 64'hFF7F_0080_FFFF_0100, 7, 0, 0, "R7");
        apply(64'hFF80_0042_8000_7FFF, 64'hFF7F_0080_FFFF_0100, 7, 2, 1, "R7");
        // R8: any opcode
        for (int o = 0; o < 8; o++)
            apply(64'hDEAD_BEEF_0123_4567, 64'h89AB_CDEF_FFFF_0001, o, 3, o[0], "R8");
        apply(64'h1, 64'h1, 0, 0, 0, "R8 legal again");

        // Mixed traffic, compared every clock (R9 back-to-back latency)
        for (int n = 0; n < 600; n++) begin
            logic [63:0] a = {$urandom, $urandom};
            logic [63:0] b = {$urandom, $urandom};
            int o = int'($urandom % 8);
            int w = ($urandom % 8 == 0) ? 3 : int'($urandom % 3);
            bit s = 1'($urandom);
            if ($urandom % 4 == 0) a = a | 64'h8080_8080_8080_8080;
            if ($urandom % 4 == 0) b = b & 64'h7F7F_7F7F_7F7F_7F7F;
            apply(a, b, o, w, s, tag_of(o, w, s));
        end

        // R9: reset mid-stream clears outputs
        opa = 64'hFFFF; opb = 64'h1; op = 3'd0; wsel = 2'd0; sgn = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R9 async clear", {illegal_o, result_o}, 65'd0);
        @(negedge clk);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R9 got=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule